// File: doc/BRIEF.md
# Non-volatile Wiper Store Sequencer

This block owns the persistent copy of a set of initial wiper positions and a few general-purpose bytes for a multi-channel digital potentiometer. After a power-on reset it drives every wiper register to midscale and holds it there until the supply is declared valid. It then waits a settling interval and loads each wiper register in turn with its stored initial position. A power-up busy output tells the serial bus engine to stay idle until the last wiper has been loaded.

In normal operation the register bank hands over write requests aimed at the persistent store. The first valid request of a bus transaction is held as pending, and any later request in that transaction is dropped. The commit does not start until the bus STOP arrives. It then runs a self-timed cycle of a programmable number of clocks, with a write-in-progress flag high for the whole cycle. The register bank exposes this flag to software as bit 5 of its access control register. The store is a flop array with its own clear input, so a power-on reset of the sequencer leaves the stored contents as they were.

Top module: `nvs_seq`

## Requirements
- R1: While the sequencer waits for the supply or counts the settling interval, `wiper_load_o` is all ones and `wiper_val_o` equals the midscale value 64 (40h). This state is entered asynchronously on `rst_ni` low.
- R2: The sequencer holds the midscale force and keeps `pwrup_busy_o` high for as long as `supply_ok_i` stays low.
- R3: The sequencer samples `supply_ok_i` high at a clock edge. After that edge and SETTLE_CYC more edges, it loads wiper k in cycle k of the recall phase, for k = 0 upward, one per cycle. During that cycle `wiper_load_o` has only bit k set and `wiper_val_o` carries the stored byte at address k.
- R4: `pwrup_busy_o` falls SETTLE_CYC+NUM_WIPER+1 edges after `supply_ok_i` is first driven high, and it stays low until the next reset. While it is low, `wiper_load_o` is zero.
- R5: Write requests and STOPs that arrive while `pwrup_busy_o` is high have no effect on the store, and `wip_o` stays low.
- R6: A pending write does not raise `wip_o` and does not change the store before the STOP.
- R7: `wip_o` rises in the cycle after the clock edge that samples `stop_i` with a write pending. The pending write may arrive in the same cycle as the STOP. `wip_o` stays high for exactly WRITE_CYC cycles.
- R8: The store location keeps its old value while `wip_o` is high. It takes the new value at the edge where `wip_o` falls.
- R9: Only the first valid write request of a transaction is committed. Later requests before the STOP are discarded.
- R10: Write requests and STOPs that arrive while `wip_o` is high are ignored. They neither extend the cycle nor start a new one.
- R11: A write request to an address of 7 or above is ignored and does not count as the first write of its transaction.
- R12: The stored bytes survive a pulse on `rst_ni` alone. `mem_rst_ni` low sets addresses 0..3 to 64 and addresses 4..6 to 0.
- R13: `rd_data_o` shows the stored byte at `rd_addr_i` combinationally. Addresses 0..3 hold the wiper initial values, 4..6 hold the general-purpose bytes, and any higher address reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous power-on reset of the sequencer |
| mem_rst_ni | input | 1 | Active-low asynchronous clear of the persistent array |
| supply_ok_i | input | 1 | Supply high enough for a reliable recall |
| wr_req_i | input | 1 | One-cycle write request from the register bank |
| wr_addr_i | input | AW (3) | Target address of the write request |
| wr_data_i | input | DATA_W (8) | Write data |
| stop_i | input | 1 | One-cycle pulse on a bus STOP |
| rd_addr_i | input | AW (3) | Read address |
| rd_data_o | output | DATA_W (8) | Stored byte at rd_addr_i |
| wiper_load_o | output | NUM_WIPER (4) | Per-wiper load strobe |
| wiper_val_o | output | DATA_W (8) | Value for the wipers strobed this cycle |
| pwrup_busy_o | output | 1 | High until the recall has finished |
| wip_o | output | 1 | Write-in-progress flag |

## Verification
The bench builds the block with SETTLE_CYC=5 and WRITE_CYC=9 and keeps the default four wipers and three general-purpose bytes. These short intervals let the bench check every cycle of the power-up sequence against a computed load pattern and time each commit to the exact cycle. They also let it sweep a commit through every valid address, plus the out-of-range one, within a short run. Warm and cold resets are replayed with non-default stored values, so the recall order and persistence are checked against data that differs per wiper.

// File: rtl/nvs_pkg.sv
package nvs_pkg;
  typedef enum logic [1:0] {RC_HOLD, RC_SETTLE, RC_LOAD, RC_DONE} rc_state_e;
  typedef enum logic [1:0] {CM_IDLE, CM_PEND, CM_BUSY} cm_state_e;
endpackage

// File: rtl/nvs_store.sv
module nvs_store #(
  parameter int DATA_W  = 8,
  parameter int NUM_IVR = 4,
  parameter int NUM_GP  = 3,
  parameter int MID_VAL = 64,
  parameter int AW      = 3,
  localparam int NUM_SLOTS = NUM_IVR + NUM_GP
) (
  input  logic                        clk_i,
  input  logic                        mem_rst_ni,
  input  logic                        we_i,
  input  logic [AW-1:0]               waddr_i,
  input  logic [DATA_W-1:0]           wdata_i,
  output logic [NUM_SLOTS*DATA_W-1:0] slots_o
);
  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
    localparam logic [DATA_W-1:0] RST_V = (s < NUM_IVR) ? DATA_W'(MID_VAL) : '0;
    logic [DATA_W-1:0] q;
    always_ff @(posedge clk_i or negedge mem_rst_ni) begin
      if (!mem_rst_ni) q <= RST_V;
      else if (we_i && waddr_i == AW'(s)) q <= wdata_i;
    end
    assign slots_o[s*DATA_W +: DATA_W] = q;
  end
endmodule

// File: rtl/nvs_recall.sv
module nvs_recall
  import nvs_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int NUM_IVR    = 4,
  parameter int SETTLE_CYC = 16,
  parameter int MID_VAL    = 64,
  localparam int IW = (NUM_IVR > 1) ? $clog2(NUM_IVR) : 1,
  localparam int CW = $clog2(SETTLE_CYC + 1)
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      supply_ok_i,
  input  logic [NUM_IVR*DATA_W-1:0] ivr_i,
  output logic [NUM_IVR-1:0]        load_o,
  output logic [DATA_W-1:0]         val_o,
  output logic                      busy_o
);
  rc_state_e     state_q;
  logic [CW-1:0] cnt_q;
  logic [IW-1:0] idx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= RC_HOLD;
      cnt_q   <= '0;
      idx_q   <= '0;
    end else begin
      case (state_q)
        RC_HOLD: if (supply_ok_i) begin
          state_q <= RC_SETTLE;
          cnt_q   <= '0;
        end
        RC_SETTLE: begin
          if (cnt_q == CW'(SETTLE_CYC - 1)) begin
            state_q <= RC_LOAD;
            idx_q   <= '0;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        RC_LOAD: begin
          if (idx_q == IW'(NUM_IVR - 1)) state_q <= RC_DONE;
          else idx_q <= idx_q + 1'b1;
        end
        default: state_q <= RC_DONE;
      endcase
    end
  end

  always_comb begin
    load_o = '0;
    val_o  = '0;
    case (state_q)
      RC_HOLD, RC_SETTLE: begin
        load_o = '1;
        val_o  = DATA_W'(MID_VAL);
      end
      RC_LOAD: begin
        load_o = NUM_IVR'(1) << idx_q;
        val_o  = ivr_i[int'(idx_q)*DATA_W +: DATA_W];
      end
      default: ;
    endcase
  end

  assign busy_o = (state_q != RC_DONE);
endmodule

// File: rtl/nvs_commit.sv
module nvs_commit
  import nvs_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int AW        = 3,
  parameter int NUM_SLOTS = 7,
  parameter int WRITE_CYC = 64,
  localparam int TW = $clog2(WRITE_CYC + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              enable_i,
  input  logic              wr_req_i,
  input  logic [AW-1:0]     wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              stop_i,
  output logic              we_o,
  output logic [AW-1:0]     waddr_o,
  output logic [DATA_W-1:0] wdata_o,
  output logic              wip_o
);
  cm_state_e         state_q;
  logic [TW-1:0]     cnt_q;
  logic [AW-1:0]     addr_q;
  logic [DATA_W-1:0] data_q;
  logic              valid_wr;
  logic              last_cyc;

  assign valid_wr = enable_i && wr_req_i && (wr_addr_i < AW'(NUM_SLOTS));
  assign last_cyc = (cnt_q == TW'(WRITE_CYC - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= CM_IDLE;
      cnt_q   <= '0;
      addr_q  <= '0;
      data_q  <= '0;
    end else begin
      case (state_q)
        CM_IDLE: if (valid_wr) begin
          addr_q  <= wr_addr_i;
          data_q  <= wr_data_i;
          cnt_q   <= '0;
          state_q <= stop_i ? CM_BUSY : CM_PEND;
        end
        CM_PEND: if (stop_i && enable_i) begin
          cnt_q   <= '0;
          state_q <= CM_BUSY;
        end
        CM_BUSY: begin
          if (last_cyc) state_q <= CM_IDLE;
          else cnt_q <= cnt_q + 1'b1;
        end
        default: state_q <= CM_IDLE;
      endcase
    end
  end

  assign wip_o   = (state_q == CM_BUSY);
  assign we_o    = wip_o && last_cyc;
  assign waddr_o = addr_q;
  assign wdata_o = data_q;
endmodule

// File: rtl/nvs_seq.sv
module nvs_seq #(
  parameter int DATA_W     = 8,
  parameter int NUM_WIPER  = 4,
  parameter int NUM_GP     = 3,
  parameter int MID_VAL    = 64,
  parameter int SETTLE_CYC = 375000,
  parameter int WRITE_CYC  = 1500000,
  localparam int NUM_SLOTS = NUM_WIPER + NUM_GP,
  localparam int AW        = $clog2(NUM_SLOTS + 1)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 mem_rst_ni,
  input  logic                 supply_ok_i,
  input  logic                 wr_req_i,
  input  logic [AW-1:0]        wr_addr_i,
  input  logic [DATA_W-1:0]    wr_data_i,
  input  logic                 stop_i,
  input  logic [AW-1:0]        rd_addr_i,
  output logic [DATA_W-1:0]    rd_data_o,
  output logic [NUM_WIPER-1:0] wiper_load_o,
  output logic [DATA_W-1:0]    wiper_val_o,
  output logic                 pwrup_busy_o,
  output logic                 wip_o
);
  logic [NUM_SLOTS*DATA_W-1:0] slots;
  logic                        st_we;
  logic [AW-1:0]               st_waddr;
  logic [DATA_W-1:0]           st_wdata;

  nvs_store #(
    .DATA_W(DATA_W), .NUM_IVR(NUM_WIPER), .NUM_GP(NUM_GP),
    .MID_VAL(MID_VAL), .AW(AW)
  ) u_store (
    .clk_i      (clk_i),
    .mem_rst_ni (mem_rst_ni),
    .we_i       (st_we),
    .waddr_i    (st_waddr),
    .wdata_i    (st_wdata),
    .slots_o    (slots)
  );

  nvs_recall #(
    .DATA_W(DATA_W), .NUM_IVR(NUM_WIPER),
    .SETTLE_CYC(SETTLE_CYC), .MID_VAL(MID_VAL)
  ) u_recall (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .supply_ok_i (supply_ok_i),
    .ivr_i       (slots[NUM_WIPER*DATA_W-1:0]),
    .load_o      (wiper_load_o),
    .val_o       (wiper_val_o),
    .busy_o      (pwrup_busy_o)
  );

  nvs_commit #(
    .DATA_W(DATA_W), .AW(AW), .NUM_SLOTS(NUM_SLOTS), .WRITE_CYC(WRITE_CYC)
  ) u_commit (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .enable_i  (!pwrup_busy_o),
    .wr_req_i  (wr_req_i),
    .wr_addr_i (wr_addr_i),
    .wr_data_i (wr_data_i),
    .stop_i    (stop_i),
    .we_o      (st_we),
    .waddr_o   (st_waddr),
    .wdata_o   (st_wdata),
    .wip_o     (wip_o)
  );

  always_comb begin
    rd_data_o = '0;
    for (int s = 0; s < NUM_SLOTS; s++) begin
      if (rd_addr_i == AW'(s)) rd_data_o = slots[s*DATA_W +: DATA_W];
    end
  end
endmodule

// File: rtl/nvs_seq_chk.sv
module nvs_seq_chk #(
  parameter int DATA_W    = 8,
  parameter int NUM_WIPER = 4,
  parameter int AW        = 3,
  parameter int MID_VAL   = 64,
  parameter int WRITE_CYC = 64
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 mem_rst_ni,
  input logic                 supply_ok_i,
  input logic                 stop_i,
  input logic [AW-1:0]        rd_addr_i,
  input logic [DATA_W-1:0]    rd_data_o,
  input logic [NUM_WIPER-1:0] wiper_load_o,
  input logic [DATA_W-1:0]    wiper_val_o,
  input logic                 pwrup_busy_o,
  input logic                 wip_o
);
  logic [31:0] wip_len;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) wip_len <= '0;
    else if (wip_o) wip_len <= wip_len + 1;
    else wip_len <= '0;
  end

  assert_mid_force_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (&wiper_load_o) |-> (wiper_val_o == DATA_W'(MID_VAL)));
  assert_hold_no_supply_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(&wiper_load_o) && !$past(supply_ok_i) && pwrup_busy_o) |-> (&wiper_load_o));
  assert_recall_onehot_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(&wiper_load_o) |-> $onehot0(wiper_load_o));
  assert_busy_sticky_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pwrup_busy_o |=> !pwrup_busy_o);
  assert_no_load_after_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pwrup_busy_o |-> (wiper_load_o == '0));
  assert_no_wip_pwrup_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pwrup_busy_o |-> !wip_o);
  assert_wip_after_stop_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(wip_o) |-> $past(stop_i));
  assert_wip_len_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(wip_o) |-> (wip_len == 32'(WRITE_CYC)));
  assert_wip_bound_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wip_o |-> (wip_len < 32'(WRITE_CYC)));
  assert_store_stable_R8: assert property (@(posedge clk_i) disable iff (!rst_ni || !mem_rst_ni)
    ($stable(rd_addr_i) && !$fell(wip_o)) |-> $stable(rd_data_o));
endmodule

bind nvs_seq nvs_seq_chk #(
  .DATA_W(DATA_W), .NUM_WIPER(NUM_WIPER), .AW(AW),
  .MID_VAL(MID_VAL), .WRITE_CYC(WRITE_CYC)
) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .mem_rst_ni   (mem_rst_ni),
  .supply_ok_i  (supply_ok_i),
  .stop_i       (stop_i),
  .rd_addr_i    (rd_addr_i),
  .rd_data_o    (rd_data_o),
  .wiper_load_o (wiper_load_o),
  .wiper_val_o  (wiper_val_o),
  .pwrup_busy_o (pwrup_busy_o),
  .wip_o        (wip_o)
);

// File: tb/nvs_seq_tb.sv
module nvs_seq_tb;
  localparam int DW = 8;
  localparam int NW = 4;
  localparam int NG = 3;
  localparam int NS = NW + NG;
  localparam int AW = 3;
  localparam int SETTLE = 5;
  localparam int WCYC = 9;

  logic clk_i = 1'b0;
  logic rst_ni, mem_rst_ni, supply_ok_i, wr_req_i, stop_i;
  logic [AW-1:0] wr_addr_i, rd_addr_i;
  logic [DW-1:0] wr_data_i, rd_data_o, wiper_val_o;
  logic [NW-1:0] wiper_load_o;
  logic pwrup_busy_o, wip_o;

  int checks = 0;
  int fails = 0;
  logic [DW-1:0] exp_mem [NS];
  logic [DW-1:0] wmodel [NW];

  always #4 clk_i = ~clk_i;

  nvs_seq #(.DATA_W(DW), .NUM_WIPER(NW), .NUM_GP(NG), .MID_VAL(64),
            .SETTLE_CYC(SETTLE), .WRITE_CYC(WCYC)) u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .mem_rst_ni(mem_rst_ni),
    .supply_ok_i(supply_ok_i), .wr_req_i(wr_req_i), .wr_addr_i(wr_addr_i),
    .wr_data_i(wr_data_i), .stop_i(stop_i), .rd_addr_i(rd_addr_i),
    .rd_data_o(rd_data_o), .wiper_load_o(wiper_load_o),
    .wiper_val_o(wiper_val_o), .pwrup_busy_o(pwrup_busy_o), .wip_o(wip_o));

  always @(posedge clk_i) begin
    for (int k = 0; k < NW; k++) if (wiper_load_o[k]) wmodel[k] <= wiper_val_o;
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk_i);
    #2;
  endtask

  task automatic set_defaults();
    for (int a = 0; a < NS; a++) exp_mem[a] = (a < NW) ? 8'd64 : 8'd0;
  endtask

  task automatic nv_wr(input int a, input int d);
    wr_req_i = 1'b1; wr_addr_i = AW'(a); wr_data_i = DW'(d);
    tick();
    wr_req_i = 1'b0;
  endtask

  task automatic read_all(input string req);
    for (int a = 0; a < 8; a++) begin
      rd_addr_i = AW'(a);
      #1;
      chk(req, int'(rd_data_o), (a < NS) ? int'(exp_mem[a]) : 0);
    end
  endtask

  // stop with a write pending; returns after wip falls
  task automatic commit(input int a);
    int n = 0;
    rd_addr_i = AW'(a);
    stop_i = 1'b1;
    tick();
    stop_i = 1'b0;
    while (wip_o && n < WCYC + 5) begin
      if (rd_data_o != exp_mem[a]) chk("R8 old value during wip", int'(rd_data_o), int'(exp_mem[a]));
      n++;
      tick();
    end
    chk("R7 wip length", n, WCYC);
  endtask

  task automatic power_up();
    supply_ok_i = 1'b1;
    for (int j = 1; j <= SETTLE + NW + 3; j++) begin
      tick();
      if (j <= SETTLE) begin
        chk("R1 force during settle", int'(wiper_load_o), (1 << NW) - 1);
      end else if (j <= SETTLE + NW) begin
        chk("R3 load order", int'(wiper_load_o), 1 << (j - SETTLE - 1));
        chk("R3 load value", int'(wiper_val_o), int'(exp_mem[j - SETTLE - 1]));
      end else begin
        chk("R4 no load after recall", int'(wiper_load_o), 0);
      end
      if (j == SETTLE + NW) chk("R4 busy before end", int'(pwrup_busy_o), 1);
      if (j == SETTLE + NW + 1) chk("R4 busy falls", int'(pwrup_busy_o), 0);
    end
    for (int k = 0; k < NW; k++) chk("R3 wiper recalled", int'(wmodel[k]), int'(exp_mem[k]));
  endtask

  initial begin
    #(8 * 150000);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    rst_ni = 1'b0; mem_rst_ni = 1'b0; supply_ok_i = 1'b0;
    wr_req_i = 1'b0; stop_i = 1'b0; wr_addr_i = '0; wr_data_i = '0; rd_addr_i = '0;
    set_defaults();
    repeat (3) tick();
    chk("R1 busy in reset", int'(pwrup_busy_o), 1);
    chk("R1 load all in reset", int'(wiper_load_o), 15);
    chk("R1 midscale value", int'(wiper_val_o), 64);
    chk("R1 no wip in reset", int'(wip_o), 0);

    rst_ni = 1'b1; mem_rst_ni = 1'b1;
    repeat (8) tick();
    nv_wr(2, 8'hAA);
    stop_i = 1'b1; tick(); stop_i = 1'b0;
    repeat (8) tick();
    chk("R2 busy while supply low", int'(pwrup_busy_o), 1);
    chk("R2 still forcing", int'(wiper_load_o), 15);
    chk("R5 no wip in power-up", int'(wip_o), 0);
    rd_addr_i = 3'd2; #1;
    chk("R5 store untouched", int'(rd_data_o), 64);

    power_up();
    read_all("R13 default readback");

    // commit sweep over all valid addresses
    for (int a = 0; a < NS; a++) begin
      int d = (a * 37 + 5) & 255;
      nv_wr(a, d);
      rd_addr_i = AW'(a);
      for (int w = 0; w < 3; w++) begin
        tick();
        chk("R6 no wip before stop", int'(wip_o), 0);
        chk("R6 store unchanged before stop", int'(rd_data_o), int'(exp_mem[a]));
      end
      commit(a);
      exp_mem[a] = DW'(d);
      chk("R8 new value after wip", int'(rd_data_o), d);
    end
    read_all("R13 sweep readback");

    // two writes in one transaction
    nv_wr(1, 8'h5A);
    nv_wr(2, 8'hC3);
    commit(1);
    exp_mem[1] = 8'h5A;
    read_all("R9 only first committed");

    // out-of-range address
    nv_wr(7, 8'hEE);
    stop_i = 1'b1; tick(); stop_i = 1'b0;
    tick();
    chk("R11 no wip for bad address", int'(wip_o), 0);
    nv_wr(7, 8'hEE);
    nv_wr(5, 8'h77);
    commit(5);
    exp_mem[5] = 8'h77;
    read_all("R11 bad address skipped");

    // requests during the write cycle
    begin
      int n = 1;
      nv_wr(3, 8'h99);
      stop_i = 1'b1; tick(); stop_i = 1'b0;
      tick(); n++;
      nv_wr(6, 8'h12); n++;
      stop_i = 1'b1; tick(); stop_i = 1'b0; n++;
      while (wip_o && n < WCYC + 5) begin n++; tick(); end
      chk("R10 cycle not extended", n - 1, WCYC);
      exp_mem[3] = 8'h99;
      repeat (3) begin
        tick();
        chk("R10 no new cycle", int'(wip_o), 0);
      end
      read_all("R10 busy write ignored");
    end

    // write and stop in the same cycle
    wr_req_i = 1'b1; wr_addr_i = 3'd4; wr_data_i = 8'h3C; stop_i = 1'b1;
    rd_addr_i = 3'd4;
    tick();
    wr_req_i = 1'b0; stop_i = 1'b0;
    begin
      int n = 0;
      while (wip_o && n < WCYC + 5) begin n++; tick(); end
      chk("R7 same-cycle stop length", n, WCYC);
    end
    exp_mem[4] = 8'h3C;
    read_all("R7 same-cycle commit");

    // warm reset keeps contents, recall uses them
    supply_ok_i = 1'b0; rst_ni = 1'b0;
    tick(); tick();
    read_all("R12 persist across reset");
    rst_ni = 1'b1;
    repeat (3) tick();
    chk("R2 busy after warm reset", int'(pwrup_busy_o), 1);
    power_up();

    // cold clear
    rst_ni = 1'b0; mem_rst_ni = 1'b0;
    tick();
    set_defaults();
    read_all("R12 cold clear");
    rst_ni = 1'b1; mem_rst_ni = 1'b1;
    tick();

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule